// File: doc/BRIEF.md
# ATM Cell Header Admission Classifier

This block sits at the receive side of an ATM cell path. For each incoming cell header it gets the VPI and VCI values, the HEC check result and the connection-table entry already fetched for that header. It then settles one outcome for the cell. It also forms the table lookup index from a programmable number of low VPI bits placed above a programmable number of low VCI bits. Any header bit above those counts marks the cell as out of range.

A 22-bit control register sets the bit counts and the policy bits. Software writes it through a set strobe and a clear strobe. The policy bits cover out-of-range cells, zero table entries, HEC errors, which source feeds the error counter, a processing hold, and the translation cache. A separate register holds the connection number that out-of-range cells are sent to. Each accepted header yields one registered decision: a disposition code, the lookup index, the chosen connection, an event flag, the echoed cell address and an error-count pulse.

Top module: `atm_hdr_classifier`

## Requirements
- R1: After reset the control register reads 0x0010 (VCI count 16, all other bits zero), flush_req and cache_off are low, the out-of-range connection is 0 and no decision is output.
- R2: A set strobe ORs ctl_wdata into the control register and a clear strobe clears the bits that are one in ctl_wdata; when both strobes come in the same cycle the set wins. Field layout: [4:0] VCI count, [9:5] VPI count, 10 no-correct, 11 accept-bad-HEC, 12 ignore-HEC, 13 in-range-index, 14 hold, 15 count-non-user, 16 soft-reset, 17 flush, 18 cache-off, 19 out-of-range event-only, 20 zero-entry accept, 21 out-of-range redirect.
- R3: flush_req and cache_off reflect bits 17 and 18; a flush_done pulse clears bit 17 unless the same cycle sets it.
- R4: The lookup index is {VPI[np-1:0], VCI[nc-1:0]} placed in the low np+nc bits, zero above; counts above 12 (VPI) or 16 (VCI) are clamped to those values.
- R5: A header with any nonzero VPI bit at or above np, or any nonzero VCI bit at or above nc, is out of range; with the redirect bit set it gets code 2 (redirect), the out-of-range connection and event high.
- R6: Redirect outranks the in-range-index bit, which outranks the event-only bit; with the in-range-index bit the cell is handled as an in-range cell.
- R7: An out-of-range cell with only the event-only bit gets code 3 (event) with event high and connection 0; with no out-of-range policy bit it gets code 0 (drop).
- R8: An in-range cell whose table entry is zero gets code 3 with event high if the zero-entry bit is set, else code 0; a nonzero entry gives code 1 (accept) with that entry as the connection.
- R9: HEC status encodes 0 clean, 1 corrected, 2 or 3 uncorrectable; an uncorrectable header, or a corrected one while no-correct is set, is bad and gets code 4 (exception) if accept-bad-HEC is set, else code 0, before any range or entry check.
- R10: err_pulse comes with the decision: in count-non-user mode it equals the header's non-user flag, otherwise it is high for a bad HEC while ignore-HEC is clear.
- R11: A header strobed with hdr_valid yields exactly one decision with dec_valid high on the next cycle, carrying its cell address; while the hold or soft-reset bit is set, headers yield no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_set_we | input | 1 | Set strobe for the control register |
| ctl_clr_we | input | 1 | Clear strobe for the control register |
| ctl_wdata | input | 22 | Bit mask for set or clear |
| oor_we | input | 1 | Write strobe for the out-of-range connection |
| oor_wdata | input | CONN_W | Out-of-range connection value |
| flush_done | input | 1 | Cache flush completed |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_vpi | input | VPI_W | Header VPI |
| hdr_vci | input | VCI_W | Header VCI |
| hdr_hec | input | 2 | HEC check status |
| hdr_non_user | input | 1 | Header is a non-user cell |
| hdr_entry | input | CONN_W | Table entry fetched for this header |
| hdr_addr | input | ADDR_W | Cell buffer address |
| ctl_rd | output | 22 | Control register contents |
| flush_req | output | 1 | Cache flush requested |
| cache_off | output | 1 | Translation cache disabled |
| dec_valid | output | 1 | Decision valid |
| dec_disp | output | 3 | Disposition code |
| dec_index | output | VPI_W+VCI_W | Lookup index |
| dec_conn | output | CONN_W | Chosen connection |
| dec_event | output | 1 | Raise an event for this cell |
| dec_addr | output | ADDR_W | Cell address echoed |
| err_pulse | output | 1 | Error counter increment |

## Verification
The bench drives headers that are out of range with several policy bits set together. A wrong priority order shows up there as a redirect turning into an accept or an event. It sets the bit counts to zero, to their maximum and above the maximum. A bad clamp or mask then leaks high bits into the index or flags in-range cells as out of range. It combines bad HEC with out-of-range headers and with the ignore and non-user count modes. A design that checks range before HEC, or that counts the wrong source, then shows the wrong code or a stray err_pulse. It also drives a set and a clear in the same cycle, a flush completion and the hold bit. These catch the wrong priority between strobes, a flush bit that never clears, and decisions made while processing is held.

// File: rtl/atm_hdr_pkg.sv
package atm_hdr_pkg;

    localparam int CTL_W = 22;

    // control register bit positions (software-visible layout)
    localparam int B_NOCOR   = 10;
    localparam int B_ACCBAD  = 11;
    localparam int B_IGNHEC  = 12;
    localparam int B_INRNG   = 13;
    localparam int B_HOLD    = 14;
    localparam int B_NONUSR  = 15;
    localparam int B_SRST    = 16;
    localparam int B_FLUSH   = 17;
    localparam int B_CACHOFF = 18;
    localparam int B_OOREVT  = 19;
    localparam int B_ZEROACC = 20;
    localparam int B_OORRED  = 21;

    localparam logic [CTL_W-1:0] CTL_RESET = 22'h00_0010;

    typedef enum logic [2:0] {
        DISP_DROP     = 3'd0,
        DISP_ACCEPT   = 3'd1,
        DISP_REDIRECT = 3'd2,
        DISP_EVENT    = 3'd3,
        DISP_EXCEPT   = 3'd4
    } disp_e;

    typedef enum logic [1:0] {
        HEC_CLEAN = 2'd0,
        HEC_FIXED = 2'd1,
        HEC_BAD   = 2'd2,
        HEC_BAD2  = 2'd3
    } hec_e;

endpackage

// File: rtl/atm_hdr_ctl.sv
module atm_hdr_ctl
    import atm_hdr_pkg::*;
#(
    parameter int CONN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [CTL_W-1:0]  wdata,
    input  logic              oor_we,
    input  logic [CONN_W-1:0] oor_wdata,
    input  logic              flush_done,
    output logic [CTL_W-1:0]  ctl,
    output logic [CONN_W-1:0] oor_conn
);

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [CONN_W-1:0] oor;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (flush_done)
            r_d.ctl[B_FLUSH] = 1'b0;
        if (clr_we)
            r_d.ctl = r_d.ctl & ~wdata;
        if (set_we)
            r_d.ctl = r_d.ctl | wdata;
        if (oor_we)
            r_d.oor = oor_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctl <= CTL_RESET;
            r_q.oor <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctl      = r_q.ctl;
    assign oor_conn = r_q.oor;

    // R3: completion clears the flush request unless re-set in the same cycle
    a_r3_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_done && !(set_we && wdata[B_FLUSH])) |=> !ctl[B_FLUSH]);

    // R2: every set bit is present after a set strobe
    a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((ctl & $past(wdata)) == $past(wdata)));

    // R2: a lone clear removes the masked bits
    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((ctl & $past(wdata)) == '0));

endmodule

// File: rtl/atm_hdr_index.sv
module atm_hdr_index
    import atm_hdr_pkg::*;
#(
    parameter int VPI_W = 12,
    parameter int VCI_W = 16,
    parameter int CNT_W = 5
) (
    input  logic [VPI_W-1:0]       vpi,
    input  logic [VCI_W-1:0]       vci,
    input  logic [CNT_W-1:0]       np_field,
    input  logic [CNT_W-1:0]       nc_field,
    output logic [VPI_W+VCI_W-1:0] index,
    output logic                   out_of_range
);

    localparam int IDX_W = VPI_W + VCI_W;

    logic [CNT_W-1:0] np_c, nc_c;
    logic [VPI_W-1:0] vpi_mask, vpi_low;
    logic [VCI_W-1:0] vci_mask, vci_low;

    always_comb begin
        np_c = (np_field > CNT_W'(VPI_W)) ? CNT_W'(VPI_W) : np_field;
        nc_c = (nc_field > CNT_W'(VCI_W)) ? CNT_W'(VCI_W) : nc_field;

        vpi_mask = ~({VPI_W{1'b1}} << np_c);
        vci_mask = ~({VCI_W{1'b1}} << nc_c);
        vpi_low  = vpi & vpi_mask;
        vci_low  = vci & vci_mask;

        out_of_range = (|(vpi & ~vpi_mask)) || (|(vci & ~vci_mask));

        index = ({{VCI_W{1'b0}}, vpi_low} << nc_c) |
                IDX_W'({{VPI_W{1'b0}}, vci_low});
    end

endmodule

// File: rtl/atm_hdr_policy.sv
module atm_hdr_policy
    import atm_hdr_pkg::*;
#(
    parameter int CONN_W = 16
) (
    input  logic              oor,
    input  logic [1:0]        hec,
    input  logic              non_user,
    input  logic [CONN_W-1:0] entry,
    input  logic [CONN_W-1:0] oor_conn,
    input  logic              p_nocor,
    input  logic              p_accbad,
    input  logic              p_ignhec,
    input  logic              p_inrng,
    input  logic              p_nonusr,
    input  logic              p_oorevt,
    input  logic              p_zeroacc,
    input  logic              p_oorred,
    output disp_e             disp,
    output logic [CONN_W-1:0] conn,
    output logic              event_o,
    output logic              err
);

    logic bad_hec;

    always_comb begin
        bad_hec = (hec == HEC_BAD) || (hec == HEC_BAD2) ||
                  ((hec == HEC_FIXED) && p_nocor);

        err     = p_nonusr ? non_user : (bad_hec && !p_ignhec);
        disp    = DISP_DROP;
        conn    = '0;
        event_o = 1'b0;

        if (bad_hec) begin
            disp = p_accbad ? DISP_EXCEPT : DISP_DROP;
        end else if (oor && p_oorred) begin
            disp    = DISP_REDIRECT;
            conn    = oor_conn;
            event_o = 1'b1;
        end else if (oor && !p_inrng) begin
            if (p_oorevt) begin
                disp    = DISP_EVENT;
                event_o = 1'b1;
            end
        end else if (entry == '0) begin
            if (p_zeroacc) begin
                disp    = DISP_EVENT;
                event_o = 1'b1;
            end
        end else begin
            disp = DISP_ACCEPT;
            conn = entry;
        end
    end

endmodule

// File: rtl/atm_hdr_classifier.sv
module atm_hdr_classifier
    import atm_hdr_pkg::*;
#(
    parameter int VPI_W  = 12,
    parameter int VCI_W  = 16,
    parameter int CNT_W  = 5,
    parameter int CONN_W = 16,
    parameter int ADDR_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_set_we,
    input  logic                   ctl_clr_we,
    input  logic [21:0]            ctl_wdata,
    input  logic                   oor_we,
    input  logic [CONN_W-1:0]      oor_wdata,
    input  logic                   flush_done,
    input  logic                   hdr_valid,
    input  logic [VPI_W-1:0]       hdr_vpi,
    input  logic [VCI_W-1:0]       hdr_vci,
    input  logic [1:0]             hdr_hec,
    input  logic                   hdr_non_user,
    input  logic [CONN_W-1:0]      hdr_entry,
    input  logic [ADDR_W-1:0]      hdr_addr,
    output logic [21:0]            ctl_rd,
    output logic                   flush_req,
    output logic                   cache_off,
    output logic                   dec_valid,
    output logic [2:0]             dec_disp,
    output logic [VPI_W+VCI_W-1:0] dec_index,
    output logic [CONN_W-1:0]      dec_conn,
    output logic                   dec_event,
    output logic [ADDR_W-1:0]      dec_addr,
    output logic                   err_pulse
);

    localparam int IDX_W = VPI_W + VCI_W;

    logic [CTL_W-1:0]  ctl;
    logic [CONN_W-1:0] oor_conn;
    logic [IDX_W-1:0]  idx_c;
    logic              oor_c;
    disp_e             disp_c;
    logic [CONN_W-1:0] conn_c;
    logic              event_c;
    logic              err_c;
    logic              hold;

    atm_hdr_ctl #(.CONN_W(CONN_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_we     (ctl_set_we),
        .clr_we     (ctl_clr_we),
        .wdata      (ctl_wdata),
        .oor_we     (oor_we),
        .oor_wdata  (oor_wdata),
        .flush_done (flush_done),
        .ctl        (ctl),
        .oor_conn   (oor_conn)
    );

    atm_hdr_index #(.VPI_W(VPI_W), .VCI_W(VCI_W), .CNT_W(CNT_W)) u_index (
        .vpi          (hdr_vpi),
        .vci          (hdr_vci),
        .np_field     (ctl[5 +: CNT_W]),
        .nc_field     (ctl[0 +: CNT_W]),
        .index        (idx_c),
        .out_of_range (oor_c)
    );

    atm_hdr_policy #(.CONN_W(CONN_W)) u_policy (
        .oor       (oor_c),
        .hec       (hdr_hec),
        .non_user  (hdr_non_user),
        .entry     (hdr_entry),
        .oor_conn  (oor_conn),
        .p_nocor   (ctl[B_NOCOR]),
        .p_accbad  (ctl[B_ACCBAD]),
        .p_ignhec  (ctl[B_IGNHEC]),
        .p_inrng   (ctl[B_INRNG]),
        .p_nonusr  (ctl[B_NONUSR]),
        .p_oorevt  (ctl[B_OOREVT]),
        .p_zeroacc (ctl[B_ZEROACC]),
        .p_oorred  (ctl[B_OORRED]),
        .disp      (disp_c),
        .conn      (conn_c),
        .event_o   (event_c),
        .err       (err_c)
    );

    typedef struct packed {
        logic              valid;
        disp_e             disp;
        logic [IDX_W-1:0]  index;
        logic [CONN_W-1:0] conn;
        logic              evt;
        logic [ADDR_W-1:0] addr;
        logic              err;
    } dec_t;

    dec_t dec_d, dec_q;

    assign hold = ctl[B_HOLD] | ctl[B_SRST];

    always_comb begin
        dec_d       = dec_q;
        dec_d.valid = 1'b0;
        dec_d.err   = 1'b0;
        if (hdr_valid && !hold) begin
            dec_d.valid = 1'b1;
            dec_d.disp  = disp_c;
            dec_d.index = idx_c;
            dec_d.conn  = conn_c;
            dec_d.evt   = event_c;
            dec_d.addr  = hdr_addr;
            dec_d.err   = err_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q.valid <= 1'b0;
            dec_q.disp  <= DISP_DROP;
            dec_q.index <= '0;
            dec_q.conn  <= '0;
            dec_q.evt   <= 1'b0;
            dec_q.addr  <= '0;
            dec_q.err   <= 1'b0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign ctl_rd    = ctl;
    assign flush_req = ctl[B_FLUSH];
    assign cache_off = ctl[B_CACHOFF];
    assign dec_valid = dec_q.valid;
    assign dec_disp  = dec_q.disp;
    assign dec_index = dec_q.index;
    assign dec_conn  = dec_q.conn;
    assign dec_event = dec_q.evt;
    assign dec_addr  = dec_q.addr;
    assign err_pulse = dec_q.err;

    // R11: a strobed header while processing is enabled gives a decision next cycle
    a_r11_one_decision: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !ctl[B_HOLD] && !ctl[B_SRST]) |=> dec_valid);

    // R11: no decision without a header one cycle earlier, none while held
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> ($past(hdr_valid) && !$past(ctl[B_HOLD]) && !$past(ctl[B_SRST])));

    // R5: a redirect carries the out-of-range connection and an event
    a_r5_redirect_conn: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_disp == 3'd2) |-> (dec_event && dec_conn == $past(oor_conn)));

    // R10: error pulses appear only with a decision
    a_r10_err_with_dec: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> dec_valid);

    // R9: exception code only when the accept-bad-HEC policy was on
    a_r9_except_policy: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_disp == 3'd4) |-> $past(ctl[B_ACCBAD]));

endmodule

// File: tb/atm_hdr_classifier_tb.sv
module atm_hdr_classifier_tb;

    localparam logic [21:0] NP4NC8 = 22'h00088;
    localparam logic [21:0] NP0NC4 = 22'h00004;
    localparam logic [21:0] NPMAX  = 22'h00190;
    localparam logic [21:0] NPOVER = 22'h003FF;
    localparam logic [21:0] NOCOR  = 22'h00400;
    localparam logic [21:0] ACCBAD = 22'h00800;
    localparam logic [21:0] IGN    = 22'h01000;
    localparam logic [21:0] INR    = 22'h02000;
    localparam logic [21:0] HOLD   = 22'h04000;
    localparam logic [21:0] NONUSR = 22'h08000;
    localparam logic [21:0] EVT    = 22'h80000;
    localparam logic [21:0] ZER    = 22'h100000;
    localparam logic [21:0] RED    = 22'h200000;
    localparam logic [15:0] OORC   = 16'h0ABC;

    typedef struct packed {
        logic [21:0] ctl;
        logic [11:0] vpi;
        logic [15:0] vci;
        logic [1:0]  hec;
        logic        nu;
        logic [15:0] entry;
        logic [2:0]  disp;
        logic [27:0] idx;
        logic [15:0] conn;
        logic        ev;
        logic        err;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{NP4NC8,            12'h003, 16'h0025, 2'd0, 1'b0, 16'h0077, 3'd1, 28'h0000325, 16'h0077, 1'b0, 1'b0}, // R4 R8 accept
        '{NP4NC8|RED,        12'h013, 16'h0025, 2'd0, 1'b0, 16'h0077, 3'd2, 28'h0000325, OORC,     1'b1, 1'b0}, // R5 redirect
        '{NP4NC8|INR,        12'h013, 16'h0025, 2'd0, 1'b0, 16'h0055, 3'd1, 28'h0000325, 16'h0055, 1'b0, 1'b0}, // R6 in-range bits
        '{NP4NC8|EVT,        12'h013, 16'h0025, 2'd0, 1'b0, 16'h0055, 3'd3, 28'h0000325, 16'h0000, 1'b1, 1'b0}, // R7 event-only
        '{NP4NC8,            12'h013, 16'h0025, 2'd0, 1'b0, 16'h0055, 3'd0, 28'h0000325, 16'h0000, 1'b0, 1'b0}, // R7 drop
        '{NP4NC8|RED|INR|EVT,12'h013, 16'h0025, 2'd0, 1'b0, 16'h0055, 3'd2, 28'h0000325, OORC,     1'b1, 1'b0}, // R6 priority
        '{NP4NC8|INR|EVT,    12'h013, 16'h0025, 2'd0, 1'b0, 16'h0055, 3'd1, 28'h0000325, 16'h0055, 1'b0, 1'b0}, // R6 priority
        '{NP0NC4|EVT,        12'h000, 16'h001F, 2'd0, 1'b0, 16'h0011, 3'd3, 28'h000000F, 16'h0000, 1'b1, 1'b0}, // R5 VCI range
        '{NP4NC8|ZER,        12'h001, 16'h0002, 2'd0, 1'b0, 16'h0000, 3'd3, 28'h0000102, 16'h0000, 1'b1, 1'b0}, // R8 zero accept
        '{NP4NC8,            12'h001, 16'h0002, 2'd0, 1'b0, 16'h0000, 3'd0, 28'h0000102, 16'h0000, 1'b0, 1'b0}, // R8 zero drop
        '{NP4NC8,            12'h001, 16'h0002, 2'd2, 1'b0, 16'h0009, 3'd0, 28'h0000102, 16'h0000, 1'b0, 1'b1}, // R9 R10 bad drop
        '{NP4NC8|ACCBAD,     12'h001, 16'h0002, 2'd2, 1'b0, 16'h0009, 3'd4, 28'h0000102, 16'h0000, 1'b0, 1'b1}, // R9 exception
        '{NP4NC8|ACCBAD|IGN, 12'h001, 16'h0002, 2'd3, 1'b0, 16'h0009, 3'd4, 28'h0000102, 16'h0000, 1'b0, 1'b0}, // R10 ignore
        '{NP4NC8,            12'h001, 16'h0002, 2'd1, 1'b0, 16'h0009, 3'd1, 28'h0000102, 16'h0009, 1'b0, 1'b0}, // R9 corrected ok
        '{NP4NC8|NOCOR,      12'h001, 16'h0002, 2'd1, 1'b0, 16'h0009, 3'd0, 28'h0000102, 16'h0000, 1'b0, 1'b1}, // R9 no-correct
        '{NP4NC8|NONUSR,     12'h001, 16'h0002, 2'd0, 1'b1, 16'h0009, 3'd1, 28'h0000102, 16'h0009, 1'b0, 1'b1}, // R10 non-user
        '{NP4NC8|NONUSR,     12'h001, 16'h0002, 2'd2, 1'b0, 16'h0009, 3'd0, 28'h0000102, 16'h0000, 1'b0, 1'b0}, // R10 mode
        '{NPOVER,            12'hFFF, 16'hFFFF, 2'd0, 1'b0, 16'h0001, 3'd1, 28'hFFFFFFF, 16'h0001, 1'b0, 1'b0}, // R4 clamp
        '{NPMAX,             12'hABC, 16'h1234, 2'd0, 1'b0, 16'h0002, 3'd1, 28'hABC1234, 16'h0002, 1'b0, 1'b0}, // R4 max
        '{22'h0,             12'h000, 16'h0000, 2'd0, 1'b0, 16'h0003, 3'd1, 28'h0000000, 16'h0003, 1'b0, 1'b0}, // R4 zero counts
        '{NP4NC8|RED,        12'h013, 16'h0025, 2'd2, 1'b0, 16'h0077, 3'd0, 28'h0000325, 16'h0000, 1'b0, 1'b1}  // R9 before range
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_set_we = 1'b0, ctl_clr_we = 1'b0;
    logic [21:0] ctl_wdata = '0;
    logic        oor_we = 1'b0;
    logic [15:0] oor_wdata = '0;
    logic        flush_done = 1'b0;
    logic        hdr_valid = 1'b0;
    logic [11:0] hdr_vpi = '0;
    logic [15:0] hdr_vci = '0;
    logic [1:0]  hdr_hec = '0;
    logic        hdr_non_user = 1'b0;
    logic [15:0] hdr_entry = '0;
    logic [15:0] hdr_addr = '0;
    logic [21:0] ctl_rd;
    logic        flush_req, cache_off, dec_valid, dec_event, err_pulse;
    logic [2:0]  dec_disp;
    logic [27:0] dec_index;
    logic [15:0] dec_conn, dec_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    atm_hdr_classifier u_dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_set_we(ctl_set_we), .ctl_clr_we(ctl_clr_we), .ctl_wdata(ctl_wdata),
        .oor_we(oor_we), .oor_wdata(oor_wdata), .flush_done(flush_done),
        .hdr_valid(hdr_valid), .hdr_vpi(hdr_vpi), .hdr_vci(hdr_vci),
        .hdr_hec(hdr_hec), .hdr_non_user(hdr_non_user), .hdr_entry(hdr_entry),
        .hdr_addr(hdr_addr),
        .ctl_rd(ctl_rd), .flush_req(flush_req), .cache_off(cache_off),
        .dec_valid(dec_valid), .dec_disp(dec_disp), .dec_index(dec_index),
        .dec_conn(dec_conn), .dec_event(dec_event), .dec_addr(dec_addr),
        .err_pulse(err_pulse)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [21:0] v);
        @(negedge clk);
        ctl_clr_we = 1'b1; ctl_wdata = '1;
        @(negedge clk);
        ctl_clr_we = 1'b0; ctl_set_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_set_we = 1'b0; ctl_wdata = '0;
    endtask

    task automatic send_hdr(input vec_t v, input logic [15:0] addr);
        hdr_valid = 1'b1; hdr_vpi = v.vpi; hdr_vci = v.vci; hdr_hec = v.hec;
        hdr_non_user = v.nu; hdr_entry = v.entry; hdr_addr = addr;
        @(negedge clk);
        hdr_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ctl reset", 64'(ctl_rd), 64'h10);
        check("R1 no decision", 64'(dec_valid), 64'h0);
        check("R1 flush/cache low", 64'({flush_req, cache_off}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ctl after release", 64'(ctl_rd), 64'h10);

        // R2: set then clear, and same-cycle set wins
        ctl_set_we = 1'b1; ctl_wdata = 22'h000300;
        @(negedge clk);
        ctl_set_we = 1'b0;
        check("R2 set", 64'(ctl_rd), 64'h310);
        ctl_clr_we = 1'b1; ctl_wdata = 22'h000110;
        @(negedge clk);
        ctl_clr_we = 1'b0;
        check("R2 clear", 64'(ctl_rd), 64'h200);
        ctl_clr_we = 1'b1; ctl_set_we = 1'b1; ctl_wdata = 22'h000001;
        @(negedge clk);
        ctl_clr_we = 1'b0; ctl_set_we = 1'b0;
        check("R2 set wins", 64'(ctl_rd), 64'h201);

        // R3: flush request and cache disable, self-clearing flush
        ctl_set_we = 1'b1; ctl_wdata = 22'h060000;
        @(negedge clk);
        ctl_set_we = 1'b0;
        check("R3 flush_req set", 64'({flush_req, cache_off}), 64'h3);
        flush_done = 1'b1;
        @(negedge clk);
        flush_done = 1'b0;
        check("R3 flush cleared", 64'({flush_req, cache_off}), 64'h1);
        ctl_set_we = 1'b1; ctl_wdata = 22'h020000; flush_done = 1'b1;
        @(negedge clk);
        ctl_set_we = 1'b0; flush_done = 1'b0;
        check("R3 set over done", 64'(flush_req), 64'h1);

        oor_we = 1'b1; oor_wdata = OORC;
        @(negedge clk);
        oor_we = 1'b0;

        // main vector walk: R4..R11
        for (int i = 0; i < NV; i++) begin
            write_ctl(VECS[i].ctl);
            send_hdr(VECS[i], 16'h0100 + 16'(i));
            check($sformatf("R11 vec %0d valid", i), 64'(dec_valid), 64'h1);
            check($sformatf("R5-R9 vec %0d disp", i), 64'(dec_disp), 64'(VECS[i].disp));
            check($sformatf("R4 vec %0d index", i), 64'(dec_index), 64'(VECS[i].idx));
            check($sformatf("R8 vec %0d conn", i), 64'(dec_conn), 64'(VECS[i].conn));
            check($sformatf("R7 vec %0d event", i), 64'(dec_event), 64'(VECS[i].ev));
            check($sformatf("R10 vec %0d err", i), 64'(err_pulse), 64'(VECS[i].err));
            check($sformatf("R11 vec %0d addr", i), 64'(dec_addr), 64'(16'h0100 + 16'(i)));
            @(negedge clk);
            check($sformatf("R11 vec %0d single", i), 64'({dec_valid, err_pulse}), 64'h0);
        end

        // R11: hold bit suppresses decisions
        write_ctl(NP4NC8 | HOLD);
        send_hdr(VECS[0], 16'h0777);
        check("R11 hold no decision", 64'({dec_valid, err_pulse}), 64'h0);
        write_ctl(NP4NC8);
        send_hdr(VECS[0], 16'h0778);
        check("R11 resume after hold", 64'({dec_valid, dec_disp}), 64'h9);

        // R11: soft-reset bit also suppresses decisions
        write_ctl(NP4NC8 | 22'h010000);
        send_hdr(VECS[10], 16'h0779);
        check("R11 soft reset no decision", 64'({dec_valid, err_pulse}), 64'h0);

        finish_run();
    end

endmodule